// File: doc/BRIEF.md
# Reed-Solomon ECC Control and Status Sequencer

This block is the register front end of a Reed-Solomon error-correction engine for a NAND flash controller. Software writes a control word, streams the data bytes of one ECC step through a data-port address, and then reads back the results. The front end counts those bytes and forwards each one to the codec. When a full step has passed, it hands off to the arithmetic codec through a start/done handshake. The codec itself sits outside this block.

When encoding, the handoff happens as soon as the last byte of the step has been counted. The parity bytes that the codec returns are loaded into a byte-addressed parity window, and an encode-finished flag is raised. When decoding, the block holds after the last byte until software has written the stored parity bytes into the window and set a parity-ready control bit. Only then does it start the codec check. On completion it captures the error count, an uncorrectable flag and the per-error report words. A mask register selects which status flags drive the interrupt line.

Top module: `rs_ecc_front`

## Requirements
- R1: After synchronous reset, the control, status and interrupt-mask registers read zero, and `irq` and `cdc_start` are low.
- R2: The control register at offset 0x100 has five fields: bit 0 enable, bit 1 reset, bit 2 RS select, bit 3 direction (1 = encode, 0 = decode) and bit 4 parity-ready. Written fields read back. The reset bit reads 1 for exactly one cycle after it is written and 0 after that.
- R3: A write to the data port at offset 0x104 is counted and forwarded on `dat_valid`/`dat_byte` only while enable is 1 and the sequencer is idle. Otherwise it is ignored and does not advance the step.
- R4: In encode mode, the cycle after the STEP_BYTES-th counted byte has `cdc_start` high for one cycle with `cdc_encode` high. When `cdc_done` arrives, the parity window takes `cdc_parity_in` and status bit 2 is set.
- R5: Parity byte i (0 ≤ i < PAR_BYTES) sits at offset 0x108+i. A write stores `bus_wdata[7:0]`, and a read returns it in `bus_rdata[7:0]`.
- R6: In decode mode, after a full step `cdc_start` stays low until parity-ready reads 1. It rises two cycles after the parity-ready write, with `cdc_encode` low and `cdc_parity_out` equal to the window (byte i at bits 8i+7:8i).
- R7: On `cdc_done` in decode, status bit 3 is set, bits 31:29 take `cdc_err_count`, and bit 0 is set if the count is nonzero. Report word n, taken from `cdc_reports[32n+31:32n]`, reads at offset 0x11C+4n. Parity-ready clears.
- R8: A decode completion with `cdc_uncorrectable` high sets status bits 0 and 1.
- R9: Writing zero to the status register at offset 0x114 clears it. A nonzero write leaves it unchanged.
- R10: Writing the control reset bit clears the step byte counter and every parity byte to zero.
- R11: The mask register at offset 0x118 bits 3:0 pairs with status bits 3:0. `irq` is high when any masked status bit is set.
- R12: Clearing enable leaves the status register and report words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Masked status interrupt |
| dat_valid | output | 1 | A counted data byte is being forwarded |
| dat_byte | output | 8 | Forwarded data byte |
| cdc_start | output | 1 | One-cycle codec start |
| cdc_encode | output | 1 | Codec operation is encode |
| cdc_parity_out | output | 8*PAR_BYTES | Parity window to the codec for checking |
| cdc_done | input | 1 | Codec completion pulse |
| cdc_parity_in | input | 8*PAR_BYTES | Parity computed by the codec |
| cdc_err_count | input | 3 | Number of errors found |
| cdc_uncorrectable | input | 1 | Too many errors to correct |
| cdc_reports | input | 32*N_REPORTS | Per-error report words |

## Verification
The bench builds the block with STEP_BYTES = 16, PAR_BYTES = 9 and N_REPORTS = 4. The short step lets full encode and decode steps repeat many times within a short run. It also puts the last-byte boundary, a mid-step reset and bytes written while enable is off within reach. The full 9-byte parity window and all four report slots are kept, so the check that every parity byte reaches the codec and the report addressing are exercised at their default sizes.

// File: rtl/rs_ecc_pkg.sv
package rs_ecc_pkg;

    localparam int unsigned OFS_CTRL = 32'h100;
    localparam int unsigned OFS_DATA = 32'h104;
    localparam int unsigned OFS_PAR  = 32'h108;
    localparam int unsigned OFS_STAT = 32'h114;
    localparam int unsigned OFS_IRQM = 32'h118;
    localparam int unsigned OFS_ERR  = 32'h11C;

    localparam int CTL_RST_BIT = 1;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ENC_GO,
        SQ_ENC_WAIT,
        SQ_DEC_PARITY,
        SQ_DEC_GO,
        SQ_DEC_WAIT
    } seq_state_e;

    // bit 4 .. bit 0
    typedef struct packed {
        logic par_rdy;
        logic enc;
        logic rs;
        logic rst;
        logic en;
    } ctrl_t;

    typedef struct packed {
        logic [2:0] err_cnt;
        logic       dec_done;
        logic       enc_done;
        logic       uncor;
        logic       err;
    } stat_t;

    function automatic logic [31:0] stat_word(stat_t s);
        return {s.err_cnt, 24'd0, 1'b0, s.dec_done, s.enc_done, s.uncor, s.err};
    endfunction

endpackage

// File: rtl/rs_ecc_step_counter.sv
module rs_ecc_step_counter #(
    parameter int STEP_BYTES = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic stroke,
    output logic full_evt
);
    localparam int CW = $clog2(STEP_BYTES);
    localparam logic [CW-1:0] LAST = CW'(STEP_BYTES - 1);

    logic [CW-1:0] cnt_q;

    assign full_evt = stroke && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (stroke)
            cnt_q <= full_evt ? '0 : cnt_q + 1'b1;
    end

    // R3: each accepted byte advances the count by one
    a_r3_count_step: assert property (@(posedge clk) disable iff (rst)
        (stroke && !full_evt && !clr) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R10: a clear leaves the counter at zero
    a_r10_count_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0));
endmodule

// File: rtl/rs_ecc_parity_bank.sv
module rs_ecc_parity_bank #(
    parameter int NB = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       load,
    input  logic [8*NB-1:0]            load_val,
    input  logic                       wr_en,
    input  logic [$clog2(NB)-1:0]      wr_idx,
    input  logic [7:0]                 wr_byte,
    output logic [8*NB-1:0]            par_flat
);
    localparam int IW = $clog2(NB);

    for (genvar g = 0; g < NB; g++) begin : g_byte
        logic [7:0] b_q;
        always_ff @(posedge clk) begin
            if (rst || clr)
                b_q <= '0;
            else if (load)
                b_q <= load_val[g*8 +: 8];
            else if (wr_en && wr_idx == IW'(g))
                b_q <= wr_byte;
        end
        assign par_flat[g*8 +: 8] = b_q;
    end

    // R10: clear zeroes every parity byte
    a_r10_parity_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (par_flat == '0));

    // R4: a codec load lands in the window
    a_r4_parity_load: assert property (@(posedge clk) disable iff (rst)
        (load && !clr) |=> (par_flat == $past(load_val)));
endmodule

// File: rtl/rs_ecc_seq_fsm.sv
module rs_ecc_seq_fsm
    import rs_ecc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       full_evt,
    input  logic       enc_mode,
    input  logic       par_rdy,
    input  logic       cdc_done,
    output seq_state_e state,
    output logic       cdc_start,
    output logic       cdc_encode,
    output logic       fin_enc,
    output logic       fin_dec
);
    seq_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SQ_IDLE:       if (full_evt) st_d = enc_mode ? SQ_ENC_GO : SQ_DEC_PARITY;
            SQ_ENC_GO:     st_d = SQ_ENC_WAIT;
            SQ_ENC_WAIT:   if (cdc_done) st_d = SQ_IDLE;
            SQ_DEC_PARITY: if (par_rdy) st_d = SQ_DEC_GO;
            SQ_DEC_GO:     st_d = SQ_DEC_WAIT;
            SQ_DEC_WAIT:   if (cdc_done) st_d = SQ_IDLE;
            default:       st_d = SQ_IDLE;
        endcase
        if (clr) st_d = SQ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SQ_IDLE;
        else     st_q <= st_d;
    end

    assign state      = st_q;
    assign cdc_start  = (st_q == SQ_ENC_GO) || (st_q == SQ_DEC_GO);
    assign cdc_encode = (st_q == SQ_ENC_GO) || (st_q == SQ_ENC_WAIT);
    assign fin_enc    = (st_q == SQ_ENC_WAIT) && cdc_done;
    assign fin_dec    = (st_q == SQ_DEC_WAIT) && cdc_done;

    // R4: codec start is a single-cycle pulse
    a_r4_single_start: assert property (@(posedge clk) disable iff (rst)
        cdc_start |=> !cdc_start);

    // R6: decode holds until parity-ready
    a_r6_hold_for_parity: assert property (@(posedge clk) disable iff (rst)
        (st_q == SQ_DEC_PARITY && !par_rdy && !clr) |=> (st_q == SQ_DEC_PARITY));
endmodule

// File: rtl/rs_ecc_front.sv
module rs_ecc_front
    import rs_ecc_pkg::*;
#(
    parameter int STEP_BYTES = 512,
    parameter int PAR_BYTES  = 9,
    parameter int N_REPORTS  = 4,
    parameter int ADDR_W     = 12
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    output logic [31:0]               bus_rdata,
    output logic                      irq,
    output logic                      dat_valid,
    output logic [7:0]                dat_byte,
    output logic                      cdc_start,
    output logic                      cdc_encode,
    output logic [8*PAR_BYTES-1:0]    cdc_parity_out,
    input  logic                      cdc_done,
    input  logic [8*PAR_BYTES-1:0]    cdc_parity_in,
    input  logic [2:0]                cdc_err_count,
    input  logic                      cdc_uncorrectable,
    input  logic [32*N_REPORTS-1:0]   cdc_reports
);
    localparam int PIW = $clog2(PAR_BYTES);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);
    localparam logic [ADDR_W-1:0] A_PAR  = ADDR_W'(OFS_PAR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_IRQM = ADDR_W'(OFS_IRQM);
    localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'(OFS_ERR);

    ctrl_t                   ctrl_q;
    stat_t                   stat_q;
    logic [3:0]              mask_q;
    logic [32*N_REPORTS-1:0] rep_flat;
    logic [31:0]             stat_w;
    seq_state_e              state;
    logic                    full_evt, fin_enc, fin_dec;

    // address decode
    logic [ADDR_W-1:0] par_diff, err_diff;
    logic par_hit, err_hit;
    assign par_diff = bus_addr - A_PAR;
    assign err_diff = bus_addr - A_ERR;
    assign par_hit  = (bus_addr >= A_PAR) && (par_diff < ADDR_W'(PAR_BYTES));
    assign err_hit  = (bus_addr >= A_ERR) && (err_diff[1:0] == 2'b00)
                   && (err_diff[ADDR_W-1:2] < (ADDR_W-2)'(N_REPORTS));

    logic ctrl_wr, clr, stat_clr, stroke;
    assign ctrl_wr  = bus_we && (bus_addr == A_CTRL);
    assign clr      = ctrl_wr && bus_wdata[CTL_RST_BIT];
    assign stat_clr = bus_we && (bus_addr == A_STAT) && (bus_wdata == 32'd0);
    assign stroke   = bus_we && (bus_addr == A_DATA) && ctrl_q.en && (state == SQ_IDLE);

    assign dat_valid = stroke;
    assign dat_byte  = bus_wdata[7:0];

    rs_ecc_step_counter #(.STEP_BYTES(STEP_BYTES)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr), .stroke(stroke), .full_evt(full_evt)
    );

    rs_ecc_parity_bank #(.NB(PAR_BYTES)) u_par (
        .clk(clk), .rst(rst), .clr(clr),
        .load(fin_enc), .load_val(cdc_parity_in),
        .wr_en(bus_we && par_hit), .wr_idx(par_diff[PIW-1:0]), .wr_byte(bus_wdata[7:0]),
        .par_flat(cdc_parity_out)
    );

    rs_ecc_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .clr(clr), .full_evt(full_evt),
        .enc_mode(ctrl_q.enc), .par_rdy(ctrl_q.par_rdy), .cdc_done(cdc_done),
        .state(state), .cdc_start(cdc_start), .cdc_encode(cdc_encode),
        .fin_enc(fin_enc), .fin_dec(fin_dec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(bus_wdata[4:0]);
        end else begin
            ctrl_q.rst <= 1'b0;
            if (fin_dec) ctrl_q.par_rdy <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else if (fin_enc) begin
            stat_q.enc_done <= 1'b1;
        end else if (fin_dec) begin
            stat_q.err_cnt  <= cdc_err_count;
            stat_q.dec_done <= 1'b1;
            stat_q.uncor    <= cdc_uncorrectable;
            stat_q.err      <= cdc_uncorrectable || (cdc_err_count != 3'd0);
        end else if (stat_clr) begin
            stat_q <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (bus_we && bus_addr == A_IRQM)
            mask_q <= bus_wdata[3:0];
    end

    for (genvar g = 0; g < N_REPORTS; g++) begin : g_rep
        logic [31:0] r_q;
        always_ff @(posedge clk) begin
            if (rst)          r_q <= '0;
            else if (fin_dec) r_q <= cdc_reports[g*32 +: 32];
        end
        assign rep_flat[g*32 +: 32] = r_q;
    end

    assign stat_w = stat_word(stat_q);
    assign irq    = |(mask_q & stat_w[3:0]);

    always_comb begin
        bus_rdata = 32'd0;
        if (bus_addr == A_CTRL) bus_rdata = {27'd0, ctrl_q};
        if (bus_addr == A_STAT) bus_rdata = stat_w;
        if (bus_addr == A_IRQM) bus_rdata = {28'd0, mask_q};
        for (int i = 0; i < PAR_BYTES; i++)
            if (par_hit && par_diff == ADDR_W'(i))
                bus_rdata = {24'd0, cdc_parity_out[i*8 +: 8]};
        for (int n = 0; n < N_REPORTS; n++)
            if (err_hit && err_diff[ADDR_W-1:2] == (ADDR_W-2)'(n))
                bus_rdata = rep_flat[n*32 +: 32];
    end

    // R2: the reset field drops back after one cycle
    a_r2_rst_self_clear: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.rst && !ctrl_wr) |=> !ctrl_q.rst);

    // R7: decode completion raises decode-finished
    a_r7_dec_flag: assert property (@(posedge clk) disable iff (rst)
        fin_dec |=> stat_q.dec_done);

    // R8: uncorrectable result sets both error flags
    a_r8_uncor_flags: assert property (@(posedge clk) disable iff (rst)
        (fin_dec && cdc_uncorrectable) |=> (stat_q.err && stat_q.uncor));

    // R9: zero write clears status
    a_r9_status_clear: assert property (@(posedge clk) disable iff (rst)
        (stat_clr && !fin_enc && !fin_dec) |=> (stat_q == '0));

    // R11: interrupt needs a mask bit
    a_r11_irq_masked: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask_q != 4'd0));

    // R12: with enable off status only moves on codec or clear events
    a_r12_hold_disabled: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !stat_clr && !fin_enc && !fin_dec) |=> $stable(stat_q));
endmodule

// File: tb/rs_ecc_front_bench.sv
`timescale 1ns/1ps
module rs_ecc_front_bench;
    localparam int STEP = 16;
    localparam int NPB  = 9;
    localparam int NREP = 4;
    localparam int AW   = 12;
    localparam int ST_IDLE = 0, ST_EGO = 1, ST_EW = 2, ST_DPAR = 3, ST_DGO = 4, ST_DW = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_we = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq, dat_valid, cdc_start, cdc_encode;
    logic [7:0] dat_byte;
    logic [8*NPB-1:0] cdc_parity_out;
    logic cdc_done = 1'b0;
    logic [8*NPB-1:0] cod_par = '0;
    logic [2:0] cod_cnt = '0;
    logic cod_unc = 1'b0;
    logic [32*NREP-1:0] cod_reps = '0;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;
    int cd_wait = 0;

    // behavioural reference state
    int          m_st = 0;
    int          m_cnt = 0;
    logic [7:0]  m_par [NPB];
    logic [4:0]  m_ctl = '0;
    logic [31:0] m_stat = '0;
    logic [3:0]  m_mask = '0;
    logic [31:0] m_rep [NREP];

    rs_ecc_front #(.STEP_BYTES(STEP), .PAR_BYTES(NPB), .N_REPORTS(NREP), .ADDR_W(AW)) u_rs_ecc_front (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .dat_valid(dat_valid), .dat_byte(dat_byte),
        .cdc_start(cdc_start), .cdc_encode(cdc_encode), .cdc_parity_out(cdc_parity_out),
        .cdc_done(cdc_done), .cdc_parity_in(cod_par), .cdc_err_count(cod_cnt),
        .cdc_uncorrectable(cod_unc), .cdc_reports(cod_reps)
    );

    always #2.5 clk = ~clk;

    task automatic cmp(input logic [127:0] act, input logic [127:0] exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_dv();
        return bus_we && bus_addr == 12'h104 && m_ctl[0] && m_st == ST_IDLE;
    endfunction

    function automatic logic [31:0] exp_rd();
        int a;
        a = int'(bus_addr);
        if (a == 'h100) return {27'd0, m_ctl};
        if (a == 'h114) return m_stat;
        if (a == 'h118) return {28'd0, m_mask};
        if (a >= 'h108 && a < 'h108 + NPB) return {24'd0, m_par[a - 'h108]};
        if (a >= 'h11C && a < 'h11C + 4*NREP && a[1:0] == 2'b00) return m_rep[(a - 'h11C) / 4];
        return 32'd0;
    endfunction

    function automatic logic [8*NPB-1:0] exp_par();
        logic [8*NPB-1:0] v;
        for (int i = 0; i < NPB; i++) v[i*8 +: 8] = m_par[i];
        return v;
    endfunction

    initial begin
        for (int i = 0; i < NPB; i++) m_par[i] = '0;
        for (int i = 0; i < NREP; i++) m_rep[i] = '0;
    end

    // reference model update
    always @(posedge clk) begin : mdl
        int n_st;
        bit fe, fd, stroke, clr;
        if (rst) begin
            m_st = ST_IDLE; m_cnt = 0; m_ctl = '0; m_stat = '0; m_mask = '0;
            for (int i = 0; i < NPB; i++) m_par[i] = '0;
            for (int i = 0; i < NREP; i++) m_rep[i] = '0;
        end else begin
            fe = (m_st == ST_EW) && cdc_done;
            fd = (m_st == ST_DW) && cdc_done;
            stroke = exp_dv();
            clr = bus_we && bus_addr == 12'h100 && bus_wdata[1];
            n_st = m_st;
            if (clr) n_st = ST_IDLE;
            else case (m_st)
                ST_IDLE: if (stroke && m_cnt == STEP-1) n_st = m_ctl[3] ? ST_EGO : ST_DPAR;
                ST_EGO:  n_st = ST_EW;
                ST_EW:   if (cdc_done) n_st = ST_IDLE;
                ST_DPAR: if (m_ctl[4]) n_st = ST_DGO;
                ST_DGO:  n_st = ST_DW;
                ST_DW:   if (cdc_done) n_st = ST_IDLE;
                default: n_st = ST_IDLE;
            endcase
            if (clr) m_cnt = 0;
            else if (stroke) m_cnt = (m_cnt == STEP-1) ? 0 : m_cnt + 1;
            if (clr) begin
                for (int i = 0; i < NPB; i++) m_par[i] = '0;
            end else if (fe) begin
                for (int i = 0; i < NPB; i++) m_par[i] = cod_par[i*8 +: 8];
            end else if (bus_we && int'(bus_addr) >= 'h108 && int'(bus_addr) < 'h108 + NPB) begin
                m_par[int'(bus_addr) - 'h108] = bus_wdata[7:0];
            end
            if (bus_we && bus_addr == 12'h100) m_ctl = bus_wdata[4:0];
            else begin
                m_ctl[1] = 1'b0;
                if (fd) m_ctl[4] = 1'b0;
            end
            if (fe) m_stat[2] = 1'b1;
            else if (fd) begin
                m_stat[31:29] = cod_cnt;
                m_stat[3] = 1'b1;
                m_stat[1] = cod_unc;
                m_stat[0] = cod_unc || (cod_cnt != 0);
            end else if (bus_we && bus_addr == 12'h114 && bus_wdata == 0) m_stat = '0;
            if (fd) for (int i = 0; i < NREP; i++) m_rep[i] = cod_reps[i*32 +: 32];
            if (bus_we && bus_addr == 12'h118) m_mask = bus_wdata[3:0];
            m_st = n_st;
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            cmp(128'(dat_valid), 128'(exp_dv()), "R3", "dat_valid");
            cmp(128'(cdc_start), 128'(m_st == ST_EGO || m_st == ST_DGO), "R4", "cdc_start");
            cmp(128'(cdc_encode), 128'(m_st == ST_EGO || m_st == ST_EW), "R6", "cdc_encode");
            cmp(128'(irq), 128'(|(m_mask & m_stat[3:0])), "R11", "irq");
            cmp(128'(bus_rdata), 128'(exp_rd()), "R2", "bus_rdata");
            cmp(128'(cdc_parity_out), 128'(exp_par()), "R5", "cdc_parity_out");
        end
    end

    // codec stand-in: done three cycles after start
    always @(negedge clk) begin
        cdc_done = 1'b0;
        if (!rst) begin
            if (cd_wait > 0) begin
                cd_wait--;
                if (cd_wait == 0) cdc_done = 1'b1;
            end else if (cdc_start) cd_wait = 3;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_err++;
            $display("FAIL R1 watchdog: actual %0d cycles expected under 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bus_we = 1'b0; bus_addr = 12'h100;
        end
    endtask

    task automatic rd(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = AW'(a);
        #1;
        cmp(128'(bus_rdata), 128'(exp), tag, "register read");
    endtask

    task automatic data_bytes(input int n, input int base);
        for (int i = 0; i < n; i++) wr('h104, 32'(base + i));
    endtask

    initial begin
        logic [8*NPB-1:0] exp72;
        for (int i = 0; i < NPB; i++) cod_par[i*8 +: 8] = 8'(8'hA0 + i);
        for (int i = 0; i < NREP; i++) cod_reps[i*32 +: 32] = 32'hC0DE_0000 | i;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd('h100, 32'h0, "R1");
        rd('h114, 32'h0, "R1");
        cmp(128'(irq), 128'(0), "R1", "irq after reset");
        cmp(128'(cdc_start), 128'(0), "R1", "cdc_start after reset");
        // R2 control fields and self-clearing reset bit
        wr('h100, 32'h0D);
        rd('h100, 32'h0D, "R2");
        wr('h100, 32'h0F);
        rd('h100, 32'h0F, "R2");
        rd('h100, 32'h0D, "R2");
        // R5 parity window
        for (int i = 0; i < NPB; i++) wr('h108 + i, 32'(8'h30 + i));
        rd('h10C, 32'h34, "R5");
        rd('h110, 32'h38, "R5");
        // R10 reset clears parity
        wr('h100, 32'h0F);
        rd('h10C, 32'h0, "R10");
        // R3 and R4 encode with an enable gap
        wr('h118, 32'h4);
        data_bytes(STEP-1, 0);
        wr('h100, 32'h0C);
        data_bytes(3, 'h70);
        idle(6);
        rd('h114, 32'h0, "R3");
        wr('h100, 32'h0D);
        wr('h104, 32'h5A);
        idle(1);
        #1;
        cmp(128'(cdc_start), 128'(1), "R4", "start after last byte");
        cmp(128'(cdc_encode), 128'(1), "R4", "encode flag");
        idle(8);
        rd('h114, 32'h4, "R4");
        rd('h108, 32'hA0, "R4");
        rd('h110, 32'hA8, "R4");
        cmp(128'(irq), 128'(1), "R11", "irq on encode done");
        // R9 status clearing
        wr('h114, 32'h5);
        rd('h114, 32'h4, "R9");
        wr('h114, 32'h0);
        rd('h114, 32'h0, "R9");
        cmp(128'(irq), 128'(0), "R11", "irq after clear");
        // R6 and R7 decode
        cod_cnt = 3'd2; cod_unc = 1'b0;
        wr('h100, 32'h05);
        data_bytes(STEP, 0);
        idle(5);
        cmp(128'(cdc_start), 128'(0), "R6", "no start before parity ready");
        rd('h114, 32'h0, "R6");
        for (int i = 0; i < NPB; i++) begin
            wr('h108 + i, 32'(8'h50 + i));
            exp72[i*8 +: 8] = 8'(8'h50 + i);
        end
        wr('h100, 32'h15);
        idle(1);
        #1;
        cmp(128'(cdc_start), 128'(0), "R6", "start one cycle after ready");
        idle(1);
        #1;
        cmp(128'(cdc_start), 128'(1), "R6", "start two cycles after ready");
        cmp(128'(cdc_encode), 128'(0), "R6", "decode direction");
        cmp(128'(cdc_parity_out), 128'(exp72), "R6", "parity to codec");
        idle(8);
        rd('h114, 32'h4000_0009, "R7");
        rd('h120, 32'hC0DE_0001, "R7");
        rd('h128, 32'hC0DE_0003, "R7");
        rd('h100, 32'h05, "R7");
        // R12 disable keeps results
        wr('h100, 32'h04);
        data_bytes(3, 0);
        rd('h114, 32'h4000_0009, "R12");
        rd('h11C, 32'hC0DE_0000, "R12");
        // R8 uncorrectable
        cod_cnt = 3'd0; cod_unc = 1'b1;
        wr('h114, 32'h0);
        wr('h100, 32'h05);
        data_bytes(STEP, 0);
        wr('h100, 32'h15);
        idle(8);
        rd('h114, 32'h0000_000B, "R8");
        wr('h118, 32'h8);
        idle(1);
        #1;
        cmp(128'(irq), 128'(1), "R11", "irq on decode done");
        // R10 reset mid-step restarts the byte count
        wr('h114, 32'h0);
        wr('h100, 32'h0D);
        data_bytes(10, 0);
        wr('h100, 32'h0F);
        data_bytes(STEP-1, 0);
        idle(8);
        rd('h114, 32'h0, "R10");
        wr('h104, 32'h11);
        idle(8);
        rd('h114, 32'h4, "R10");
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule